// File: doc/BRIEF.md
# PWM Fault Override Controller

This block sits between a PWM generator and the output pads. When one of two active-low fault inputs asserts, it forces selected PWM outputs to programmed safe levels. Each fault source has its own output mask, override level pattern and mode select. In latched mode, recovery needs both the pin to be released and software to clear the fault's interrupt flag. In cycle-by-cycle mode, the override lasts only while the fault is present. In both modes the normal waveform comes back only on a PWM cycle or half-cycle boundary strobe supplied by the time base.

Fault pins pass through a two-flop synchronizer. Software can also force each fault through a manual input. Each fault has an interrupt flag that sets when the fault becomes active. While the device sleeps, any active fault raises a wake request. Fault A outranks fault B on any output that both masks select.

Top module: `pwm_fault_ovr`

## Requirements
- R1: While reset is held and after its release with all faults idle, pwm_o equals pwm_i, both flags read 0 and wake_o is 0.
- R2: A fault pin driven low forces the outputs in its mask after exactly two rising clock edges (synchronizer latency), not earlier.
- R3: Output bits outside a fault's mask follow pwm_i while that fault is active.
- R4: When both faults are active, any bit in fault A's mask (fault index 0) takes fault A's level, even if fault B's mask also covers it. Bits only in fault B's mask (index 1) take fault B's level.
- R5: A fault's flag (flag_o bit 0 = A, bit 1 = B) sets on the rising clock edge after the fault becomes active. A set outranks a clear strobe in the same cycle.
- R6: In latched mode (latch_mode_i bit = 1), the override holds while the flag is set, even when the pin is high and boundaries occur. It ends once the flag is cleared and a boundary follows.
- R7: In latched mode, clearing the flag while the fault is still active does not end the override. It ends at a boundary after the pin returns high.
- R8: In cycle-by-cycle mode (latch_mode_i bit = 0), the override ends at the first boundary after the fault goes inactive, while the flag is still set.
- R9: An override never ends without a boundary. With bound_i low, the outputs stay forced after the fault goes away.
- R10: A manual override input forces its fault's pattern in the same cycle, with no synchronizer delay, and behaves like a low pin otherwise.
- R11: wake_o is high exactly when sleep_i is high and at least one fault is active (synchronized pin low or manual set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwm_i | input | N_OUT | Raw PWM outputs from the generator |
| fault_ni | input | 2 | Fault pins, active low, bit 0 = A, bit 1 = B |
| manual_i | input | 2 | Software force of each fault |
| latch_mode_i | input | 2 | 1 = latched mode, 0 = cycle-by-cycle, per fault |
| mask_a_i | input | N_OUT | Outputs overridden by fault A |
| level_a_i | input | N_OUT | Override levels for fault A |
| mask_b_i | input | N_OUT | Outputs overridden by fault B |
| level_b_i | input | N_OUT | Override levels for fault B |
| bound_i | input | 1 | PWM cycle or half-cycle boundary strobe |
| flag_clr_i | input | 2 | Software flag clear strobes |
| sleep_i | input | 1 | Device asleep |
| pwm_o | output | N_OUT | Final outputs to the pads |
| flag_o | output | 2 | Per-fault interrupt flags |
| wake_o | output | 1 | Wake request |

## Verification
A pin change reaches the outputs after two rising edges. The flag follows one edge later. Release comes on the edge that samples bound_i high once the release conditions hold. Manual force and wake requests act combinationally in the same cycle. The bench drives inputs just after a rising edge and compares every output at the falling edge against a behavioural model that is advanced on each rising edge. Directed checks are timed by counting those edges from the stimulus. A random phase then varies masks, modes, boundaries and clears.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
  localparam int N_FLT = 2;
  localparam int FLT_A = 0;
  localparam int FLT_B = 1;
  typedef enum logic {MODE_CBC = 1'b0, MODE_LATCH = 1'b1} flt_mode_e;
endpackage

// File: rtl/pfo_sync.sv
module pfo_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  // idle level of a fault pin is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pfo_channel.sv
module pfo_channel
  import pwm_fault_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      active_i,
  input  flt_mode_e mode_i,
  input  logic      bound_i,
  input  logic      clr_i,
  output logic      flag_o,
  output logic      engaged_o
);
  logic act_q, flag_q, hold_q;
  logic set_flag, rel_ok;

  assign set_flag = active_i & ~act_q;
  assign rel_ok   = ~active_i & ((mode_i == MODE_CBC) | ~flag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      flag_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      act_q <= active_i;
      if (set_flag)    flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
      if (active_i)                         hold_q <= 1'b1;
      else if (hold_q && bound_i && rel_ok) hold_q <= 1'b0;
    end
  end

  assign flag_o    = flag_q;
  assign engaged_o = hold_q | active_i;
endmodule

// File: rtl/pfo_mux.sv
module pfo_mux #(
  parameter int N_OUT = 8
) (
  input  logic [N_OUT-1:0] pwm_i,
  input  logic [1:0]       engaged_i,
  input  logic [N_OUT-1:0] mask_a_i,
  input  logic [N_OUT-1:0] level_a_i,
  input  logic [N_OUT-1:0] mask_b_i,
  input  logic [N_OUT-1:0] level_b_i,
  output logic [N_OUT-1:0] pwm_o
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_bit
    always_comb begin
      if (engaged_i[0] && mask_a_i[i])      pwm_o[i] = level_a_i[i];
      else if (engaged_i[1] && mask_b_i[i]) pwm_o[i] = level_b_i[i];
      else                                  pwm_o[i] = pwm_i[i];
    end
  end
endmodule

// File: rtl/pwm_fault_ovr.sv
module pwm_fault_ovr
  import pwm_fault_pkg::*;
#(
  parameter int N_OUT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_OUT-1:0] pwm_i,
  input  logic [1:0]       fault_ni,
  input  logic [1:0]       manual_i,
  input  logic [1:0]       latch_mode_i,
  input  logic [N_OUT-1:0] mask_a_i,
  input  logic [N_OUT-1:0] level_a_i,
  input  logic [N_OUT-1:0] mask_b_i,
  input  logic [N_OUT-1:0] level_b_i,
  input  logic             bound_i,
  input  logic [1:0]       flag_clr_i,
  input  logic             sleep_i,
  output logic [N_OUT-1:0] pwm_o,
  output logic [1:0]       flag_o,
  output logic             wake_o
);
  logic [N_FLT-1:0] pin_s;
  logic [N_FLT-1:0] active;
  logic [N_FLT-1:0] engaged;

  pfo_sync #(.W(N_FLT), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (fault_ni),
    .q_o    (pin_s)
  );

  assign active = ~pin_s | manual_i;

  for (genvar k = 0; k < N_FLT; k++) begin : g_flt
    pfo_channel u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .active_i  (active[k]),
      .mode_i    (flt_mode_e'(latch_mode_i[k])),
      .bound_i   (bound_i),
      .clr_i     (flag_clr_i[k]),
      .flag_o    (flag_o[k]),
      .engaged_o (engaged[k])
    );
  end

  pfo_mux #(.N_OUT(N_OUT)) u_mux (
    .pwm_i     (pwm_i),
    .engaged_i (engaged),
    .mask_a_i  (mask_a_i),
    .level_a_i (level_a_i),
    .mask_b_i  (mask_b_i),
    .level_b_i (level_b_i),
    .pwm_o     (pwm_o)
  );

  assign wake_o = sleep_i & (|active);
endmodule

// File: rtl/pwm_fault_ovr_chk.sv
module pwm_fault_ovr_chk #(
  parameter int N_OUT = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bound_i,
  input logic             sleep_i,
  input logic [1:0]       latch_mode_i,
  input logic [N_OUT-1:0] pwm_i,
  input logic [N_OUT-1:0] pwm_o,
  input logic [N_OUT-1:0] mask_a_i,
  input logic [N_OUT-1:0] mask_b_i,
  input logic [N_OUT-1:0] level_a_i,
  input logic [1:0]       flag_o,
  input logic             wake_o,
  input logic [1:0]       active,
  input logic [1:0]       engaged
);
  a_r11_wake_needs_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> sleep_i);

  a_r3_unmasked_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pwm_o ^ pwm_i) & ~(mask_a_i | mask_b_i)) == '0);

  a_r4_a_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    engaged[0] |-> ((pwm_o ^ level_a_i) & mask_a_i) == '0);

  for (genvar k = 0; k < 2; k++) begin : g_k
    a_r5_flag_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(active[k]) |=> flag_o[k]);

    a_r9_release_on_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(engaged[k]) |-> $past(bound_i));

    a_r6_latched_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (latch_mode_i[k] && flag_o[k] && engaged[k]) |=> engaged[k]);
  end
endmodule

bind pwm_fault_ovr pwm_fault_ovr_chk #(.N_OUT(N_OUT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bound_i      (bound_i),
  .sleep_i      (sleep_i),
  .latch_mode_i (latch_mode_i),
  .pwm_i        (pwm_i),
  .pwm_o        (pwm_o),
  .mask_a_i     (mask_a_i),
  .mask_b_i     (mask_b_i),
  .level_a_i    (level_a_i),
  .flag_o       (flag_o),
  .wake_o       (wake_o),
  .active       (active),
  .engaged      (engaged)
);

// File: tb/pwm_fault_ovr_test.sv
`timescale 1ns/1ps
module pwm_fault_ovr_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pwm = '0, mask_a = 8'h0F, lvl_a = 8'h05, mask_b = 8'h3C, lvl_b = 8'h30;
  logic [1:0]   fault_n = 2'b11, manual = 2'b00, latch = 2'b00, clr = 2'b00;
  logic         bound = 1'b0, sleep = 1'b0;
  logic [N-1:0] pwm_o;
  logic [1:0]   flag_o;
  logic         wake_o;

  int compared = 0, mismatched = 0;

  always #5 clk = ~clk;

  pwm_fault_ovr #(.N_OUT(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .fault_ni(fault_n), .manual_i(manual),
    .latch_mode_i(latch), .mask_a_i(mask_a), .level_a_i(lvl_a), .mask_b_i(mask_b),
    .level_b_i(lvl_b), .bound_i(bound), .flag_clr_i(clr), .sleep_i(sleep),
    .pwm_o(pwm_o), .flag_o(flag_o), .wake_o(wake_o));

  // behavioural reference
  bit m_p1 [2], m_p2 [2], m_prev [2], m_flag [2], m_hold [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_p1[k] = 1; m_p2[k] = 1; m_prev[k] = 0; m_flag[k] = 0; m_hold[k] = 0;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        bit act, ok;
        act = !m_p2[k] || manual[k];
        ok  = !act && (!latch[k] || !m_flag[k]);
        if (act) m_hold[k] = 1;
        else if (m_hold[k] && bound && ok) m_hold[k] = 0;
        if (act && !m_prev[k]) m_flag[k] = 1;
        else if (clr[k]) m_flag[k] = 0;
        m_prev[k] = act;
        m_p2[k] = m_p1[k];
        m_p1[k] = fault_n[k];
      end
    end
  end

  function automatic logic [N-1:0] exp_pwm();
    logic [N-1:0] r;
    bit ea, eb;
    ea = m_hold[0] || !m_p2[0] || manual[0];
    eb = m_hold[1] || !m_p2[1] || manual[1];
    for (int i = 0; i < N; i++) begin
      if (ea && mask_a[i]) r[i] = lvl_a[i];
      else if (eb && mask_b[i]) r[i] = lvl_b[i];
      else r[i] = pwm[i];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit any_act;
      any_act = 0;
      for (int k = 0; k < 2; k++) any_act |= (!m_p2[k] || manual[k]);
      chk("R2/R3/R4 pwm_o model", pwm_o, exp_pwm());
      chk("R5 flag_o model", flag_o, {m_flag[1], m_flag[0]});
      chk("R11 wake_o model", wake_o, sleep && any_act);
    end
  end

  task automatic next_cyc();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    fault_n = 2'b11; manual = 2'b00; bound = 1'b1; clr = 2'b11;
    repeat (4) next_cyc();
    bound = 1'b0; clr = 2'b00;
    next_cyc();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    pwm = 8'h5A;
    #12;
    chk("R1 reset pwm_o", pwm_o, 8'h5A);
    chk("R1 reset flag_o", flag_o, 2'b00);
    chk("R1 reset wake_o", wake_o, 1'b0);
    next_cyc(); rst_n = 1'b1;
    next_cyc();

    // cycle-by-cycle, fault A
    fault_n = 2'b10;
    @(negedge clk); chk("R2 no early force", pwm_o, 8'h5A);
    next_cyc(); @(negedge clk); chk("R2 one edge", pwm_o, 8'h5A);
    next_cyc(); @(negedge clk); chk("R2 forced after two edges", pwm_o, 8'h55);
    next_cyc(); pwm = 8'hFA;
    @(negedge clk); chk("R3 unmasked follow", pwm_o, 8'hF5);
    chk("R5 flag A set", flag_o, 2'b01);
    next_cyc(); fault_n = 2'b11;
    repeat (5) next_cyc();
    @(negedge clk); chk("R9 held without boundary", pwm_o, 8'hF5);
    next_cyc(); bound = 1'b1;
    next_cyc(); bound = 1'b0;
    @(negedge clk); chk("R8 cbc release", pwm_o, 8'hFA);
    chk("R8 flag still set", flag_o, 2'b01);
    next_cyc(); clr = 2'b01;
    next_cyc(); clr = 2'b00;

    // latched, fault A
    latch = 2'b01; bound = 1'b1;
    next_cyc(); fault_n = 2'b10;
    repeat (3) next_cyc();
    @(negedge clk); chk("R7 forced", pwm_o, 8'hF5);
    next_cyc(); clr = 2'b01;
    next_cyc(); clr = 2'b00;
    repeat (3) next_cyc();
    @(negedge clk); chk("R7 flag cleared", flag_o, 2'b00);
    chk("R7 held while pin low", pwm_o, 8'hF5);
    next_cyc(); fault_n = 2'b11;
    repeat (4) next_cyc();
    @(negedge clk); chk("R7 released after pin high", pwm_o, 8'hFA);
    next_cyc(); fault_n = 2'b10;
    repeat (3) next_cyc();
    fault_n = 2'b11;
    repeat (4) next_cyc();
    @(negedge clk); chk("R6 held with flag set", pwm_o, 8'hF5);
    next_cyc(); clr = 2'b01;
    next_cyc(); clr = 2'b00;
    next_cyc();
    @(negedge clk); chk("R6 released after clear", pwm_o, 8'hFA);
    latch = 2'b00; settle();

    // priority with both faults
    pwm = 8'h00; fault_n = 2'b00;
    repeat (3) next_cyc();
    @(negedge clk); chk("R4 A over B", pwm_o, 8'h35);
    chk("R5 both flags", flag_o, 2'b11);
    settle();

    // manual force of B
    manual = 2'b10;
    @(negedge clk); chk("R10 manual immediate", pwm_o, 8'h30);
    next_cyc(); next_cyc();
    @(negedge clk); chk("R10 manual sets flag", flag_o, 2'b10);
    settle();

    // sleep wake
    sleep = 1'b1;
    @(negedge clk); chk("R11 no wake idle", wake_o, 1'b0);
    fault_n = 2'b10;
    next_cyc(); next_cyc();
    @(negedge clk); chk("R11 wake on fault", wake_o, 1'b1);
    sleep = 1'b0; settle();

    // random phase
    for (int n = 0; n < 3000; n++) begin
      next_cyc();
      pwm     = N'($urandom);
      fault_n = (($urandom % 8) == 0) ? 2'($urandom) : fault_n;
      manual  = (($urandom % 20) == 0) ? 2'($urandom) : 2'b00;
      bound   = (($urandom % 4) == 0);
      clr     = (($urandom % 6) == 0) ? 2'($urandom) : 2'b00;
      sleep   = (($urandom % 3) == 0);
      if (($urandom % 200) == 0) begin
        latch = 2'($urandom); mask_a = N'($urandom); mask_b = N'($urandom);
        lvl_a = N'($urandom); lvl_b = N'($urandom);
      end
    end
    next_cyc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule